// File: doc/BRIEF.md
# Word-Serial GF(2^193) Operand Unit

This unit keeps three operand registers, A, B and C, each holding one element of the binary field GF(2^193) in polynomial basis, reduced by the trinomial x^193 + x^15 + 1. A sequencing controller hands it one command at a time. Each command runs to completion, and the unit then signals that it is finished.

Field elements are far wider than the 16-bit memory port. They therefore move as thirteen words, least significant word first. Each operand register acts as a word-wide shift chain during these transfers. A load, a save, a copy from C to A and a field addition each take thirteen beats, and the addition produces one 16-bit slice per beat. Squaring is a single beat through a fixed XOR network. A product from an external multiplier can also be written into C in one beat.

A command is accepted on a clock edge where `cmd_valid` is high and `cmd_ready` is high. The memory address for the first word is taken from `cmd_addr`. Successive words use the following addresses. The memory returns read data on the clock after the address it was given.

Top module: `gf_word_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `done`, `mem_rd` and `mem_wr` are 0.
- R2: Loads use opcode 0 (into A), 1 (into B) and 2 (into C). Word k of the element (bits 16k..16k+15) is read from `cmd_addr`+k, for k = 0..12. Only bit 0 of word 12 is used; its bits 15:1 are ignored. `done` rises 13 edges after the accepting edge.
- R3: Opcode 3 writes C to addresses `cmd_addr`..`cmd_addr`+12, one word per beat and word 0 first, with bits 15:1 of word 12 set to zero. C is unchanged afterwards. `mem_wr` is high only while the unit is busy. `done` rises 13 edges after acceptance.
- R4: Opcode 4 copies C into A and leaves C unchanged. `done` rises 13 edges after acceptance.
- R5: Opcode 5 sets C to A XOR B and leaves A and B unchanged. `done` rises 13 edges after acceptance.
- R6: Opcode 6 sets C to A*A mod (x^193 + x^15 + 1). `done` rises 1 edge after acceptance.
- R7: Opcode 7 writes the 193-bit `mul_res` input into C. `done` rises 1 edge after acceptance.
- R8: `done` is a one-cycle pulse and is only high while `cmd_ready` is high. `cmd_ready` is low while a command runs, and `cmd_valid` has no effect during that time.
- R9: `mem_rd` and `mem_wr` are never high together. Consecutive write beats use consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_addr | input | 8 | Base word address |
| cmd_ready | output | 1 | Unit idle, command can be accepted |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| mul_res | input | 193 | Product from the external multiplier |

## Verification
The bench uses the default parameters: a 193-bit field, 16-bit words and an 8-bit address. With these values the thirteenth, partial word is exercised, including its ignored upper bits on load and its zero fill on save. The real trinomial reduction is also in use, so squaring operands whose upper half is populated brings both fold-back passes within reach. Squares are compared with a reference built on a multiply-and-reduce procedure rather than on bit spreading.

// File: rtl/gf_word_pkg.sv
// Shared opcodes and helpers for the word-serial GF(2^m) operand unit.
package gf_word_pkg;

    typedef enum logic [2:0] {
        OP_LDA  = 3'd0,
        OP_LDB  = 3'd1,
        OP_LDC  = 3'd2,
        OP_SAVC = 3'd3,
        OP_MOVCA = 3'd4,
        OP_ADD  = 3'd5,
        OP_SQR  = 3'd6,
        OP_MULW = 3'd7
    } op_e;

    // True for commands that pull operands from memory.
    function automatic logic op_is_load(op_e op);
        return (op == OP_LDA) || (op == OP_LDB) || (op == OP_LDC);
    endfunction

    // True for commands that finish in a single beat.
    function automatic logic op_is_single(op_e op);
        return (op == OP_SQR) || (op == OP_MULW);
    endfunction

endpackage

// File: rtl/gf_word_ctrl.sv
// Command sequencer: accepts one command while idle, counts word beats,
// drives the memory strobes and address, and pulses done at the end.
// Assumes memory returns read data one cycle after the address.
module gf_word_ctrl
    import gf_word_pkg::*;
#(
    parameter int NWORDS = 13,
    parameter int ADDR_W = 8,
    localparam int BEAT_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              busy,
    output op_e               op_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr
);

    logic              busy_q;
    logic [ADDR_W-1:0] base_q;
    logic              done_q;
    logic              last;

    // Final beat of the running command.
    always_comb last = op_is_single(op_q) ? 1'b1 : (beat_q == BEAT_W'(NWORDS - 1));

    // Command acceptance, beat counting and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_LDA;
            beat_q <= '0;
            base_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= busy_q && last;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q <= 1'b1;
                    op_q   <= cmd_op;
                    base_q <= cmd_addr;
                    beat_q <= '0;
                end
            end else if (last) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Memory strobes: loads prefetch one word ahead of the shift beat.
    always_comb begin
        if (!busy_q) begin
            mem_rd   = cmd_valid && op_is_load(cmd_op);
            mem_wr   = 1'b0;
            mem_addr = cmd_addr;
        end else begin
            mem_rd   = op_is_load(op_q) && !last;
            mem_wr   = (op_q == OP_SAVC);
            mem_addr = base_q + ADDR_W'(beat_q) + ADDR_W'(op_is_load(op_q));
        end
    end

    assign cmd_ready = !busy_q;
    assign busy      = busy_q;
    assign done      = done_q;

endmodule

// File: rtl/gf_squarer.sv
// Combinational squarer for GF(2^M) with trinomial x^M + x^K + 1.
// Spreads bit i to 2i, then folds terms of degree >= M downward from the
// top so that second-level folds are absorbed. Assumes 0 < K < M.
module gf_squarer #(
    parameter int M = 193,
    parameter int K = 15
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] sq
);

    logic [2*M-2:0] wide;

    // Spread and reduce; the loop unrolls into a fixed XOR network.
    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) wide[2*i] = a[i];
        for (int i = 2*M-2; i >= M; i--) begin
            wide[i-M+K] = wide[i-M+K] ^ wide[i];
            wide[i-M]   = wide[i-M]   ^ wide[i];
        end
        sq = wide[M-1:0];
    end

endmodule

// File: rtl/gf_operand_regs.sv
// Operand registers A, B and C as word-wide rotate/shift chains. Storage is
// padded to whole words; the pad bits are kept zero at all times.
module gf_operand_regs
    import gf_word_pkg::*;
#(
    parameter int M      = 193,
    parameter int WORD_W = 16,
    localparam int NWORDS = (M + WORD_W - 1) / WORD_W,
    localparam int W_TOT  = NWORDS * WORD_W,
    localparam int BEAT_W = $clog2(NWORDS),
    localparam int TOP_BITS = M - (NWORDS - 1) * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  op_e               op,
    input  logic [BEAT_W-1:0] beat,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [M-1:0]      mul_res,
    input  logic [M-1:0]      sq_res,
    output logic [M-1:0]      a_val,
    output logic [WORD_W-1:0] wr_word
);

    localparam logic [WORD_W-1:0] TOP_MASK = {WORD_W{1'b1}} >> (WORD_W - TOP_BITS);

    logic [W_TOT-1:0]  a_q, b_q, c_q;
    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] a_lo, b_lo, c_lo;

    // Shift a word in at the top, dropping the bottom word.
    function automatic logic [W_TOT-1:0] push(logic [W_TOT-1:0] r, logic [WORD_W-1:0] w);
        return {w, r[W_TOT-1:WORD_W]};
    endfunction

    // Incoming memory word, partial top word zero-filled.
    always_comb word_in = (beat == BEAT_W'(NWORDS - 1)) ? (mem_rdata & TOP_MASK) : mem_rdata;

    assign a_lo = a_q[WORD_W-1:0];
    assign b_lo = b_q[WORD_W-1:0];
    assign c_lo = c_q[WORD_W-1:0];

    // Register A: load, copy from C, or rotate during addition.
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else if (step) begin
            case (op)
                OP_LDA:   a_q <= push(a_q, word_in);
                OP_MOVCA: a_q <= push(a_q, c_lo);
                OP_ADD:   a_q <= push(a_q, a_lo);
                default:  a_q <= a_q;
            endcase
        end
    end

    // Register B: load or rotate during addition.
    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else if (step) begin
            case (op)
                OP_LDB:  b_q <= push(b_q, word_in);
                OP_ADD:  b_q <= push(b_q, b_lo);
                default: b_q <= b_q;
            endcase
        end
    end

    // Register C: load, rotate out, sum slice, square or product.
    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else if (step) begin
            case (op)
                OP_LDC:   c_q <= push(c_q, word_in);
                OP_SAVC,
                OP_MOVCA: c_q <= push(c_q, c_lo);
                OP_ADD:   c_q <= push(c_q, a_lo ^ b_lo);
                OP_SQR:   c_q <= W_TOT'(sq_res);
                OP_MULW:  c_q <= W_TOT'(mul_res);
                default:  c_q <= c_q;
            endcase
        end
    end

    assign a_val   = a_q[M-1:0];
    assign wr_word = c_lo;

endmodule

// File: rtl/gf_word_unit.sv
// Top level: word-serial GF(2^193) operand unit with a 16-bit memory port.
// Assumes a synchronous memory with one cycle of read latency.
module gf_word_unit
    import gf_word_pkg::*;
#(
    parameter int M      = 193,
    parameter int K      = 15,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    localparam int NWORDS = (M + WORD_W - 1) / WORD_W,
    localparam int BEAT_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [M-1:0]      mul_res
);

    logic              busy;
    op_e               op_q;
    logic [BEAT_W-1:0] beat_q;
    logic [M-1:0]      a_val;
    logic [M-1:0]      sq_res;

    gf_word_ctrl #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk, .rst_n, .cmd_valid, .cmd_op(op_e'(cmd_op)), .cmd_addr,
        .cmd_ready, .busy, .op_q, .beat_q, .done, .mem_rd, .mem_wr, .mem_addr
    );

    gf_operand_regs #(.M(M), .WORD_W(WORD_W)) u_regs (
        .clk, .rst_n, .step(busy), .op(op_q), .beat(beat_q), .mem_rdata,
        .mul_res, .sq_res, .a_val, .wr_word(mem_wdata)
    );

    gf_squarer #(.M(M), .K(K)) u_sq (.a(a_val), .sq(sq_res));

endmodule

// File: rtl/gf_word_unit_chk.sv
// Protocol checker for gf_word_unit, attached by bind.
module gf_word_unit_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> cmd_ready);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
    a_r9_wr_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + 1'b1));
    a_r3_wr_only_busy: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !cmd_ready);

endmodule

bind gf_word_unit gf_word_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk, .rst_n, .cmd_ready, .done, .mem_rd, .mem_wr, .mem_addr
);

// File: tb/gf_word_unit_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module gf_word_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int M = 193;
    localparam int NW = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [7:0]   cmd_addr = 8'd0;
    logic         cmd_ready, done, mem_rd, mem_wr;
    logic [7:0]   mem_addr;
    logic [15:0]  mem_wdata;
    logic [15:0]  mem_rdata;
    logic [M-1:0] mul_res = '0;

    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf_word_unit u_dut (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_ready, .done,
        .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata, .mul_res
    );

    // Synchronous word memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(string req, logic [M-1:0] act, logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference product: shift-and-add, then reduce by x^193+x^15+1.
    function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b);
        logic [2*M-1:0] acc = '0;
        for (int i = 0; i < M; i++) if (b[i]) acc = acc ^ ({{M{1'b0}}, a} << i);
        for (int i = 2*M-1; i >= M; i--) if (acc[i]) begin
            acc[i] = 1'b0;
            acc[i-M] = ~acc[i-M];
            acc[i-M+15] = ~acc[i-M+15];
        end
        return acc[M-1:0];
    endfunction

    function automatic logic [M-1:0] rnd_elem();
        logic [M-1:0] v;
        for (int i = 0; i < NW; i++) v[16*i +: 16] = 16'($urandom);
        return v;
    endfunction

    // Place an element in memory; junk in bits 15:1 of the top word.
    task automatic put_elem(int base, logic [M-1:0] v);
        for (int i = 0; i < NW - 1; i++) mem[base+i] = v[16*i +: 16];
        mem[base+NW-1] = {15'h5A5A, v[M-1]};
    endtask

    function automatic logic [M-1:0] get_elem(int base);
        logic [M-1:0] v;
        for (int i = 0; i < NW - 1; i++) v[16*i +: 16] = mem[base+i];
        v[M-1] = mem[base+NW-1][0];
        return v;
    endfunction

    // Issue one command and check the edges from acceptance to done.
    task automatic run_cmd(logic [2:0] op, logic [7:0] addr, int beats, string req);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!done && n < 40) begin @(negedge clk); n++; end
        check({req, " latency"}, M'(n), M'(beats + 1));
    endtask

    task automatic t_reset();
        check("R1 ready", M'(cmd_ready), M'(1));
        check("R1 done", M'(done), M'(0));
        check("R1 strobes", M'({mem_rd, mem_wr}), M'(0));
    endtask

    task automatic t_load_save();
        logic [M-1:0] x = rnd_elem();
        x[M-1] = 1'b1;
        put_elem(16, x);
        run_cmd(3'd2, 8'd16, 13, "R2");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R2 R3 load/save", get_elem(64), x);
        check("R3 top word zero fill", M'(mem[64+12][15:1]), M'(0));
        run_cmd(3'd3, 8'd96, 13, "R3");
        check("R3 C unchanged after save", get_elem(96), x);
    endtask

    task automatic t_add();
        logic [M-1:0] x = rnd_elem();
        logic [M-1:0] y = rnd_elem();
        put_elem(16, x); put_elem(32, y); put_elem(48, '0);
        run_cmd(3'd0, 8'd16, 13, "R2");
        run_cmd(3'd1, 8'd32, 13, "R2");
        // Start addition, then hold a square request while busy (R8).
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_addr = 8'd0;
        @(negedge clk);
        cmd_op = 3'd6;
        check("R8 not ready while busy", M'(cmd_ready), M'(0));
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R5 sum / R8 ignored request", get_elem(64), x ^ y);
        run_cmd(3'd5, 8'd0, 13, "R5");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R5 A,B unchanged", get_elem(64), x ^ y);
        run_cmd(3'd1, 8'd48, 13, "R2");
        run_cmd(3'd5, 8'd0, 13, "R5");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R5 A kept", get_elem(64), x);
    endtask

    task automatic t_move();
        logic [M-1:0] z = rnd_elem();
        put_elem(16, z); put_elem(48, '0);
        run_cmd(3'd2, 8'd16, 13, "R2");
        run_cmd(3'd4, 8'd0, 13, "R4");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R4 C unchanged", get_elem(64), z);
        run_cmd(3'd1, 8'd48, 13, "R2");
        run_cmd(3'd5, 8'd0, 13, "R5");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R4 A equals C", get_elem(64), z);
    endtask

    task automatic t_square(logic [M-1:0] a, string tag);
        put_elem(16, a);
        run_cmd(3'd0, 8'd16, 13, "R2");
        run_cmd(3'd6, 8'd0, 1, "R6");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check({"R6 square ", tag}, get_elem(64), ref_mul(a, a));
    endtask

    task automatic t_mulw();
        logic [M-1:0] p = rnd_elem();
        mul_res = p;
        run_cmd(3'd7, 8'd0, 1, "R7");
        run_cmd(3'd3, 8'd64, 13, "R3");
        check("R7 product capture", get_elem(64), p);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load_save();
        t_add();
        t_move();
        t_square(M'(1), "one");
        t_square({1'b1, {(M-1){1'b0}}}, "top bit");
        t_square({M{1'b1}}, "all ones");
        t_square(rnd_elem(), "random a");
        t_square(rnd_elem(), "random b");
        t_mulw();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule